// File: doc/BRIEF.md
# Serial LED Shift-Out Controller

This block feeds a chain of external serial-in, parallel-out shift registers that drive LEDs. Each transfer moves a 17-bit word out over a serial data pin, one bit per shift-clock period. A latch strobe then copies the shifted bits onto the register outputs. The shift clock comes from the system clock through a divider of 4, 8, 16 or 32. The clock edge can be placed a programmable number of system cycles after the data changes, so slow or long board traces still meet the external chip's setup time.

Software uses a small register interface. It can write a word to be shifted, pick the divider and the delay, and set two mode bits. The first mode bit picks the strobe polarity, which matches one of two external chip styles. The second bit switches the data source from the software word to a live 17-bit vector of PWM channel outputs. In that mode a transfer starts by itself whenever the vector holds a new non-zero pattern. A busy flag tells software when it may write again. Writes to the data word, and attempts to enter PWM mode, are dropped while busy. Before entering PWM mode, software is expected to shift out an all-zero word once.

Top module: `sled_shifter`

## Requirements
- R1: After a synchronous active-low reset, all registers read zero, the busy flag is clear, and the serial data, shift clock and strobe outputs are low.
- R2: Register 0 holds the data word in bits [16:0] and shows the busy flag in bit 31. A write to register 0, in software mode and while idle, starts a transfer, and the busy flag reads 1 in the following cycle.
- R3: A transfer sends the 17 bits most significant first. Each bit lasts one shift period of D system cycles. Data changes at the start of a period, and the shift clock is high for D/2 cycles within that period.
- R4: Register 1 bits [1:0] hold the divider code. Codes 0, 1, 2 and 3 give D = 4, 8, 16 and 32.
- R5: Register 2 bits [4:0] hold the delay value v. The shift clock rises min(v+1, D/2) cycles after the start of each bit period.
- R6: After the last bit, the strobe is active for exactly one shift period, with the shift clock and serial data low. Busy then falls, so busy lasts 18*D cycles in total.
- R7: Register 3 bit 0 selects the strobe polarity. With 0 the strobe is idle low and pulses high. With 1 it is idle high and pulses low.
- R8: A write to register 0 while busy is ignored, including in the last busy cycle. The stored word stays the same and no further transfer follows.
- R9: Register 3 bit 1 enables PWM mode. Setting it while busy leaves it at 0. Setting it while idle takes effect.
- R10: In PWM mode, when idle, a transfer starts whenever the PWM input vector is non-zero and differs from the last word shifted. The word sent is the vector sampled in the start cycle.
- R11: In PWM mode, an all-zero vector never starts a transfer, and neither does a vector equal to the last word shifted. A software write to register 0 is stored but starts no transfer.
- R12: A PWM vector that changes during a transfer starts the next transfer in the cycle right after busy falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wr_en_i | input | 1 | Register write strobe |
| addr_i | input | 2 | Register select (0 data, 1 divider, 2 delay, 3 mode) |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data for the selected register (combinational) |
| pwm_i | input | 17 | Live PWM channel levels, used in PWM mode |
| sdata_o | output | 1 | Serial data to the shift register chain |
| sclk_o | output | 1 | Shift clock |
| latch_o | output | 1 | Latch strobe, polarity set by the style bit |

## Verification
The sharpest collision is when a new request lands in the same cycle as the end of a transfer. This can be a software write in the final strobe cycle, or a PWM vector that changed mid-transfer and is waiting for busy to fall. The bench places a data write exactly in the last busy cycle and checks that the word is not stored and that busy stays low afterwards. It also changes the PWM vector partway through a transfer and checks that busy is low for exactly one cycle before the new word starts shifting. A sweep over every divider code and several delays, including ones past the clamp, decodes the pins cycle by cycle against expected values computed from D and the delay.

// File: rtl/sled_pkg.sv
// Shared definitions for the serial LED shift-out controller.
// Assumes a four-entry register map selected by a 2-bit address.
package sled_pkg;
    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_DIV  = 2'd1,
        REG_DLY  = 2'd2,
        REG_MODE = 2'd3
    } reg_sel_e;

    localparam int MODE_STYLE_BIT = 0;
    localparam int MODE_PWM_BIT   = 1;
    localparam int DIV_CODE_W     = 2;
endpackage

// File: rtl/sled_regfile.sv
// Register file: data word, divider code, delay and mode bits.
// Assumes busy comes from the shift engine. Blocks data writes and
// PWM-mode entry while busy, and flags a software start request.
module sled_regfile
    import sled_pkg::*;
#(
    parameter int DATA_W = 17,
    parameter int DLY_W  = 5,
    parameter int BUS_W  = 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [1:0]            addr,
    input  logic [BUS_W-1:0]      wdata,
    input  logic                  busy,
    output logic [DATA_W-1:0]     data_q,
    output logic [DIV_CODE_W-1:0] div_q,
    output logic [DLY_W-1:0]      dly_q,
    output logic                  style_q,
    output logic                  pwm_q,
    output logic                  sw_start,
    output logic [DATA_W-1:0]     sw_word,
    output logic [BUS_W-1:0]      rdata
);
    logic unused_hi;
    assign unused_hi = ^wdata[BUS_W-1:DATA_W];

    // Register updates with write blocking while a transfer runs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_q  <= '0;
            div_q   <= '0;
            dly_q   <= '0;
            style_q <= 1'b0;
            pwm_q   <= 1'b0;
        end else if (wr_en) begin
            case (reg_sel_e'(addr))
                REG_DATA: if (!busy) data_q <= wdata[DATA_W-1:0];
                REG_DIV:  div_q <= wdata[DIV_CODE_W-1:0];
                REG_DLY:  dly_q <= wdata[DLY_W-1:0];
                REG_MODE: begin
                    style_q <= wdata[MODE_STYLE_BIT];
                    if (!(busy && !pwm_q)) pwm_q <= wdata[MODE_PWM_BIT];
                end
                default: ;
            endcase
        end
    end

    // Software start: idle data write outside PWM mode.
    always_comb begin
        sw_start = wr_en && (reg_sel_e'(addr) == REG_DATA) && !busy && !pwm_q;
        sw_word  = wdata[DATA_W-1:0];
    end

    // Read multiplexer.
    always_comb begin
        rdata = '0;
        case (reg_sel_e'(addr))
            REG_DATA: begin
                rdata[DATA_W-1:0] = data_q;
                rdata[BUS_W-1]    = busy;
            end
            REG_DIV:  rdata[DIV_CODE_W-1:0] = div_q;
            REG_DLY:  rdata[DLY_W-1:0] = dly_q;
            REG_MODE: begin
                rdata[MODE_STYLE_BIT] = style_q;
                rdata[MODE_PWM_BIT]   = pwm_q;
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/sled_phase.sv
// Bit-period timer: counts system cycles within one shift period of
// D = 2**(BASE_LOG+code) cycles and places the high half of the shift
// clock after a clamped delay. Assumes restart and run come from the engine.
module sled_phase
    import sled_pkg::*;
#(
    parameter int BASE_LOG = 2,
    parameter int DLY_W    = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  run,
    input  logic                  restart,
    input  logic [DIV_CODE_W-1:0] div_code,
    input  logic [DLY_W-1:0]      dly,
    output logic                  period_end,
    output logic                  sclk_hi
);
    localparam int CNT_W = BASE_LOG + (1 << DIV_CODE_W) - 1;
    localparam int CW    = CNT_W + DLY_W + 1;

    logic [CNT_W-1:0] cnt_q;
    logic [CW-1:0]    div_n, half_n, dly_p1, eff_n, cnt_x;

    // Divider, half period and clamped clock delay.
    always_comb begin
        div_n  = CW'(1) << (BASE_LOG + int'(div_code));
        half_n = div_n >> 1;
        dly_p1 = CW'(dly) + CW'(1);
        eff_n  = (dly_p1 > half_n) ? half_n : dly_p1;
        cnt_x  = CW'(cnt_q);
        period_end = (cnt_x == div_n - CW'(1));
        sclk_hi    = (cnt_x >= eff_n) && (cnt_x < eff_n + half_n);
    end

    // Phase counter, cleared on a new transfer, wraps each period.
    always_ff @(posedge clk) begin
        if (!rst_n)              cnt_q <= '0;
        else if (restart)        cnt_q <= '0;
        else if (run) begin
            if (period_end)      cnt_q <= '0;
            else                 cnt_q <= cnt_q + CNT_W'(1);
        end
    end
endmodule

// File: rtl/sled_engine.sv
// Shift engine: starts transfers from software or PWM requests, sends
// the word MSB first, then runs one strobe period. Assumes the software
// start is already qualified by idle and software mode.
module sled_engine #(
    parameter int DATA_W = 17
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sw_start,
    input  logic [DATA_W-1:0] sw_word,
    input  logic              pwm_mode,
    input  logic [DATA_W-1:0] pwm_vec,
    input  logic              style,
    input  logic              period_end,
    input  logic              sclk_hi,
    output logic              busy,
    output logic              start,
    output logic              sdata,
    output logic              sclk,
    output logic              latch
);
    localparam int IDX_W = $clog2(DATA_W + 1);

    logic [IDX_W-1:0]  idx_q;
    logic [DATA_W-1:0] shreg_q, last_q, start_word;
    logic              pwm_start, in_latch;

    // Start arbitration; the two sources are mutually exclusive by mode.
    always_comb begin
        pwm_start  = pwm_mode && !busy && (|pwm_vec) && (pwm_vec != last_q);
        start      = sw_start || pwm_start;
        start_word = pwm_mode ? pwm_vec : sw_word;
    end

    // Transfer state: busy, bit index, shift register, last word sent.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy    <= 1'b0;
            idx_q   <= '0;
            shreg_q <= '0;
            last_q  <= '0;
        end else if (start) begin
            busy    <= 1'b1;
            idx_q   <= '0;
            shreg_q <= start_word;
            last_q  <= start_word;
        end else if (busy && period_end) begin
            if (idx_q == IDX_W'(DATA_W)) busy <= 1'b0;
            idx_q   <= idx_q + IDX_W'(1);
            shreg_q <= shreg_q << 1;
        end
    end

    // Pin decode from transfer state.
    always_comb begin
        in_latch = busy && (idx_q == IDX_W'(DATA_W));
        sdata    = busy && !in_latch && shreg_q[DATA_W-1];
        sclk     = busy && !in_latch && sclk_hi;
        latch    = in_latch ^ style;
    end
endmodule

// File: rtl/sled_shifter.sv
// Top of the serial LED shift-out controller: register file, bit-period
// timer and shift engine. Assumes a single synchronous clock domain.
module sled_shifter
    import sled_pkg::*;
#(
    parameter int DATA_W   = 17,
    parameter int DLY_W    = 5,
    parameter int BASE_LOG = 2,
    parameter int BUS_W    = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [1:0]        addr_i,
    input  logic [BUS_W-1:0]  wdata_i,
    output logic [BUS_W-1:0]  rdata_o,
    input  logic [DATA_W-1:0] pwm_i,
    output logic              sdata_o,
    output logic              sclk_o,
    output logic              latch_o
);
    logic [DATA_W-1:0]     data_q, sw_word;
    logic [DIV_CODE_W-1:0] div_q;
    logic [DLY_W-1:0]      dly_q;
    logic                  style_q, pwm_q, sw_start;
    logic                  busy, start, period_end, sclk_hi;

    sled_regfile #(.DATA_W(DATA_W), .DLY_W(DLY_W), .BUS_W(BUS_W)) u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en_i), .addr(addr_i),
        .wdata(wdata_i), .busy(busy), .data_q(data_q), .div_q(div_q),
        .dly_q(dly_q), .style_q(style_q), .pwm_q(pwm_q),
        .sw_start(sw_start), .sw_word(sw_word), .rdata(rdata_o)
    );

    sled_phase #(.BASE_LOG(BASE_LOG), .DLY_W(DLY_W)) u_phase (
        .clk(clk), .rst_n(rst_n), .run(busy), .restart(start),
        .div_code(div_q), .dly(dly_q),
        .period_end(period_end), .sclk_hi(sclk_hi)
    );

    sled_engine #(.DATA_W(DATA_W)) u_engine (
        .clk(clk), .rst_n(rst_n), .sw_start(sw_start), .sw_word(sw_word),
        .pwm_mode(pwm_q), .pwm_vec(pwm_i), .style(style_q),
        .period_end(period_end), .sclk_hi(sclk_hi), .busy(busy),
        .start(start), .sdata(sdata_o), .sclk(sclk_o), .latch(latch_o)
    );
endmodule

// File: rtl/sled_shifter_chk.sv
// Property checker for sled_shifter, attached by bind.
module sled_shifter_chk #(
    parameter int DATA_W = 17
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en_i,
    input logic [1:0]        addr_i,
    input logic              busy,
    input logic              pwm_q,
    input logic              style_q,
    input logic              sclk_o,
    input logic              sdata_o,
    input logic              latch_o,
    input logic [DATA_W-1:0] data_q,
    input logic [DATA_W-1:0] pwm_i
);
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!sclk_o && !sdata_o && (latch_o == style_q))); // R7
    AST_STROBE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_o != style_q) |-> (busy && !sclk_o && !sdata_o)); // R6
    AST_DATA_HELD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0 && busy) |=> $stable(data_q)); // R8
    AST_PWM_ENTRY_BLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !pwm_q) |=> !pwm_q); // R9
    AST_PWM_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (pwm_q && !busy && pwm_i == '0) |=> !busy); // R11
    AST_SW_START: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && addr_i == 2'd0 && !busy && !pwm_q) |=> busy); // R2
endmodule

bind sled_shifter sled_shifter_chk #(.DATA_W(DATA_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en_i), .addr_i(addr_i),
    .busy(busy), .pwm_q(pwm_q), .style_q(style_q), .sclk_o(sclk_o),
    .sdata_o(sdata_o), .latch_o(latch_o), .data_q(data_q), .pwm_i(pwm_i)
);

// File: tb/sled_shifter_bench.sv
module sled_shifter_bench;
    localparam int CLK_PERIOD = 10;
    localparam int DW = 17;

    logic          clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0;
    logic [1:0]    addr = '0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [DW-1:0] pwm = '0;
    logic          sdata, sclk, latch;
    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    sled_shifter u_sled_shifter (
        .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .addr_i(addr),
        .wdata_i(wdata), .rdata_o(rdata), .pwm_i(pwm),
        .sdata_o(sdata), .sclk_o(sclk), .latch_o(latch)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        wr_en = 1'b0; addr = 2'd0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] v);
        addr = a;
        #1 v = rdata;
        addr = 2'd0;
        #1;
    endtask

    task automatic wait_idle(input int n, input string req);
        bit ok = 1'b1;
        repeat (n) begin
            @(negedge clk);
            #1 if (rdata[31] || sclk) ok = 1'b0;
        end
        chk(ok, req, "no transfer expected", ok, 1);
    endtask

    // Decodes one transfer; called in the first busy cycle (phase 0).
    task automatic observe(input int dv, input logic st, input int pk,
                           input int pkind, input logic [1:0] pa,
                           input logic [31:0] pv,
                           output logic [DW-1:0] cap, output int nbits,
                           output int first_rise, output int hi_len,
                           output int busy_len, output int first_latch,
                           output int latch_cnt);
        logic prev = 1'b0;
        cap = '0; nbits = 0; first_rise = -1; hi_len = 0;
        busy_len = 0; first_latch = -1; latch_cnt = 0;
        for (int k = 0; k < 2000; k++) begin
            if (k == pk + 1 && pkind == 1) begin
                wr_en = 1'b0; addr = 2'd0;
            end
            #1;
            if (!rdata[31]) break;
            busy_len = k + 1;
            if (sclk && !prev) begin
                cap = {cap[DW-2:0], sdata};
                nbits++;
                if (first_rise < 0) first_rise = k;
            end
            if (sclk && k < dv) hi_len++;
            if (latch != st) begin
                latch_cnt++;
                if (first_latch < 0) first_latch = k;
            end
            prev = sclk;
            if (k == pk) begin
                if (pkind == 1) begin
                    wr_en = 1'b1; addr = pa; wdata = pv;
                end else if (pkind == 2) begin
                    pwm = pv[DW-1:0];
                end
            end
            @(negedge clk);
        end
    endtask

    task automatic run_check(input logic [DW-1:0] word, input int code,
                             input int dly, input logic st, input int pk,
                             input int pkind, input logic [1:0] pa,
                             input logic [31:0] pv);
        int d, h, e;
        logic [DW-1:0] cap;
        int nbits, fr, hl, bl, fl, lc;
        d = 4 << code;
        h = d / 2;
        e = (dly + 1 > h) ? h : dly + 1;
        observe(d, st, pk, pkind, pa, pv, cap, nbits, fr, hl, bl, fl, lc);
        chk(cap == word, "R3", "captured word", cap, word);
        chk(nbits == DW, "R3", "shift clock rises", nbits, DW);
        chk(hl == h, "R3", "shift clock high cycles", hl, h);
        chk(fr == e, "R5", "first rise offset", fr, e);
        chk(bl == 18 * d, "R4", "busy length", bl, 18 * d);
        chk(fl == 17 * d, "R6", "strobe start", fl, 17 * d);
        chk(lc == d, "R6", "strobe length", lc, d);
    endtask

    initial begin
        logic [31:0] v;
        logic [DW-1:0] w;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        #1;
        chk(!sclk && !sdata && !latch, "R1", "pins after reset",
            {sclk, sdata, latch}, 0);
        for (int a = 0; a < 4; a++) begin
            rd(2'(a), v);
            chk(v == 0, "R1", "register after reset", v, 0);
        end

        // Sweep divider codes, delays (including clamped ones) and styles.
        for (int c = 0; c < 4; c++) begin
            for (int di = 0; di < 4; di++) begin
                int h, dv;
                logic st;
                h  = (4 << c) / 2;
                dv = (di == 0) ? 0 : (di == 1) ? 1 : (di == 2) ? h - 1 : h + 3;
                st = 1'((c + di) % 2);
                w  = DW'(32'h15A5A ^ ((c * 4 + di) * 32'h1379));
                wr(2'd1, 32'(c));
                wr(2'd2, 32'(dv));
                wr(2'd3, {31'd0, st});
                #1 chk(latch == st, "R7", "idle strobe level", latch, st);
                wr(2'd0, {15'd0, w});
                run_check(w, c, dv, st, -5, 0, 2'd0, 0);
                rd(2'd0, v);
                chk(v[DW-1:0] == w && !v[31], "R2", "data readback", v, w);
            end
        end

        // Writes while busy, including the final busy cycle.
        wr(2'd1, 0); wr(2'd2, 0); wr(2'd3, 0);
        wr(2'd0, 32'h0ACE1);
        run_check(17'h0ACE1, 0, 0, 1'b0, 5, 1, 2'd0, 32'h1FFFF);
        rd(2'd0, v);
        chk(v[DW-1:0] == 17'h0ACE1, "R8", "word after busy write", v[DW-1:0], 17'h0ACE1);
        wait_idle(10, "R8");
        wr(2'd0, 32'h13579);
        run_check(17'h13579, 0, 0, 1'b0, 71, 1, 2'd0, 32'h00F0F);
        rd(2'd0, v);
        chk(v[DW-1:0] == 17'h13579, "R8", "word after last-cycle write", v[DW-1:0], 17'h13579);
        wait_idle(10, "R8");
        wr(2'd0, 32'h1C003);
        run_check(17'h1C003, 0, 0, 1'b0, 5, 1, 2'd3, 32'h2);
        rd(2'd3, v);
        chk(v == 0, "R9", "PWM entry while busy", v, 0);

        // Zero flush, then PWM mode.
        wr(2'd0, 0);
        run_check(17'h0, 0, 0, 1'b0, -5, 0, 2'd0, 0);
        wr(2'd3, 32'h2);
        rd(2'd3, v);
        chk(v == 2, "R9", "PWM entry while idle", v, 2);
        wait_idle(40, "R11");
        @(negedge clk) pwm = 17'h00C35;
        @(negedge clk);
        run_check(17'h00C35, 0, 0, 1'b0, 10, 2, 2'd0, 32'h1A0F0);  // R10
        @(negedge clk);
        #1 chk(rdata[31] == 1'b1, "R12", "restart right after busy fell", rdata[31], 1);
        run_check(17'h1A0F0, 0, 0, 1'b0, -5, 0, 2'd0, 0);
        pwm = '0;
        wait_idle(40, "R11");
        pwm = 17'h1A0F0;
        wait_idle(40, "R11");
        wr(2'd0, 32'h05555);
        wait_idle(40, "R11");
        rd(2'd0, v);
        chk(v[DW-1:0] == 17'h05555, "R11", "word stored in PWM mode", v[DW-1:0], 17'h05555);
        @(negedge clk) pwm = 17'h10001;
        @(negedge clk);
        run_check(17'h10001, 0, 0, 1'b0, -5, 0, 2'd0, 0);  // R10

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule